// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a set of configuration register byte lanes from a serial EEPROM once the global reset is released. It is the I2C master on a two-wire bus. Both lines are open drain: the block only ever pulls a line low and relies on the board's pull-up resistors for the high level. The block first sends the memory word address in a write transfer. It then issues a repeated start and reads the stored bytes one after another in a single sequential read.

The first byte returned is a load-enable marker. If the marker is all ones, the EEPROM is treated as blank: the master ends the read at once and no register lane is written. Otherwise twenty bytes follow, in this order:

1. subsystem identifier, most significant byte first (four bytes)
2. system control (four bytes)
3. general control
4. event enable
5. general output
6. terminal routing (four bytes)
7. card control
8. device control
9. diagnostic
10. power-management capability
11. identification/revision

Each byte leaves the block as a one-cycle write strobe with its lane index. The `done` output tells the rest of the chip that configuration accesses may proceed. The `err` output reports that the EEPROM did not answer. Only the global reset (`rst`) starts a load; the ordinary bus reset is not connected to this block.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: After `rst` is released, the bus carries a START, the byte 0xA0 (device address 1010000, write), the word address 0x00, a repeated START and the byte 0xA1 (same device, read), in that order.
- R2: Inside a byte, rising SCL edges are exactly 4*CLK_DIV clocks apart. While SCL is high, SDA changes only to form a START or a STOP, so a clean load shows exactly two START conditions.
- R3: If the marker byte is 0xFF, the master sends no acknowledge on it and then issues a STOP. After that, `done`=1, `err`=0, and `wr_en` never pulses.
- R4: Otherwise the next twenty bytes each give exactly one `wr_en` pulse. `wr_idx` runs from 0 to 19 in read order, and `wr_data` carries the byte as read.
- R5: The master drives an acknowledge (SDA low) after the marker and after data bytes 0 to 18. It leaves SDA high (no acknowledge) after data byte 19.
- R6: A missing acknowledge on any of the three address-phase bytes ends the transfer with a STOP. The block then shows `err`=1 and `done`=1, and no write strobe is issued.
- R7: Out of reset, `done`=0, `err`=0, `wr_en`=0, and neither line is pulled. `done` rises only after the STOP has completed. It then stays high with both lines released until the next reset.
- R8: A reset asserted in the middle of a load abandons it. The following load starts over at lane 0 and completes all twenty writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Global reset, synchronous, active high; release starts a load |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle strobe for a configuration byte |
| wr_idx | output | 5 | Lane index of the byte being written (0 to 19) |
| wr_data | output | 8 | Byte value for that lane |
| done | output | 1 | Load sequence finished; configuration access allowed |
| err | output | 1 | EEPROM failed to acknowledge an address-phase byte |

## Verification
The bench runs a behavioural EEPROM on the wired-AND lines and targets the following corner cases.

- **Acknowledge on the last byte.** A master that acknowledged the last data byte would leave the EEPROM driving the next bit, so the STOP could not form. A master that acknowledged the marker too early would have no way to abandon a blank part.
- **Marker of 0xFF.** A design that compared the marker wrongly would write twenty lanes of erased data.
- **Missing acknowledge, in each of the three address positions.** A design that ignored the fault would report success and strobe garbage into the lanes.
- **Reset in mid-load.** A design that kept its lane counter would resume at the wrong index.

The bench also checks that SCL timing and the START count expose any SDA movement while SCL is high.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

    // number of configuration byte lanes filled after the marker byte
    localparam int REG_BYTES = 20;
    localparam logic [6:0] ROM_DEV_ADDR = 7'b1010000;
    localparam logic [7:0] SKIP_MARK = 8'hFF;

    typedef enum logic [1:0] {
        OP_START,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] data;
        logic       nack_last;    // read: answer with no acknowledge
        logic       nack_if_skip; // read: no acknowledge when byte == SKIP_MARK
    } bus_cmd_t;

    typedef struct packed {
        logic [7:0] data;
        logic       peer_ack;
    } bus_rsp_t;

    typedef enum logic [3:0] {
        SQ_START_W,
        SQ_DEV_W,
        SQ_WORD,
        SQ_START_R,
        SQ_DEV_R,
        SQ_MARK,
        SQ_DATA,
        SQ_STOP,
        SQ_DONE
    } seq_state_e;

    function automatic logic [7:0] dev_byte(input logic [6:0] addr, input logic rd);
        return {addr, rd};
    endfunction

endpackage

// File: rtl/cfgld_tick.sv
`timescale 1ns/1ps
module cfgld_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // quarter-bit ticks are never back to back unless the divider is 1
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((DIV == 1) || !tick));

endmodule

// File: rtl/cfgld_bitengine.sv
`timescale 1ns/1ps
module cfgld_bitengine
    import cfgld_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     cmd_valid,
    input  bus_cmd_t cmd,
    output logic     idle,
    output logic     rsp_valid,
    output bus_rsp_t rsp,
    input  logic     sda_i,
    output logic     scl_oe,
    output logic     sda_oe
);
    logic       busy;
    bus_op_e    op;
    logic [1:0] phase;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       nack_last, nack_skip, ack_ok;
    logic       scl_drv, sda_drv;

    assign idle     = !busy;
    assign scl_oe   = scl_drv;
    assign sda_oe   = sda_drv;
    assign rsp.data = sh;
    assign rsp.peer_ack = ack_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            op        <= OP_START;
            phase     <= '0;
            bitn      <= '0;
            sh        <= '0;
            nack_last <= 1'b0;
            nack_skip <= 1'b0;
            ack_ok    <= 1'b0;
            scl_drv   <= 1'b0;
            sda_drv   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy      <= 1'b1;
                    op        <= cmd.op;
                    sh        <= cmd.data;
                    nack_last <= cmd.nack_last;
                    nack_skip <= cmd.nack_if_skip;
                    phase     <= '0;
                    bitn      <= '0;
                end
            end else if (tick) begin
                phase <= phase + 2'd1;
                unique case (phase)
                    2'd0: begin // SCL is low here: place SDA
                        case (op)
                            OP_START: sda_drv <= 1'b0;
                            OP_STOP:  sda_drv <= 1'b1;
                            OP_WRITE: sda_drv <= (bitn == 4'd8) ? 1'b0 : !sh[7];
                            OP_READ:  sda_drv <= (bitn == 4'd8) ?
                                         !(nack_last || (nack_skip && sh == SKIP_MARK)) : 1'b0;
                        endcase
                    end
                    2'd1: scl_drv <= 1'b0;
                    2'd2: begin // SCL is high here
                        case (op)
                            OP_START: sda_drv <= 1'b1;
                            OP_STOP:  sda_drv <= 1'b0;
                            OP_WRITE: if (bitn == 4'd8) ack_ok <= !sda_i;
                            OP_READ:  if (bitn != 4'd8) sh <= {sh[6:0], sda_i};
                        endcase
                    end
                    2'd3: begin
                        if (op != OP_STOP) scl_drv <= 1'b1;
                        if (op == OP_START || op == OP_STOP || bitn == 4'd8) begin
                            busy      <= 1'b0;
                            rsp_valid <= 1'b1;
                        end else begin
                            bitn <= bitn + 4'd1;
                            if (op == OP_WRITE) sh <= {sh[6:0], 1'b0};
                        end
                    end
                endcase
            end
        end
    end

    // R2: within a data byte SDA only moves while SCL is held low
    assert_sda_moves_low_scl_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && (op == OP_WRITE || op == OP_READ) && (sda_drv != $past(sda_drv)))
            |-> (scl_drv && $past(scl_drv)));

    // R7: a finished STOP leaves both lines released
    assert_bus_free_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && op == OP_STOP) |-> (!scl_drv && !sda_drv));

    // a busy engine never loses SCL ownership mid-bit without a tick
    assert_scl_only_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(tick) && $past(busy)) |-> $stable(scl_drv));

endmodule

// File: rtl/cfg_eeprom_loader.sv
`timescale 1ns/1ps
module cfg_eeprom_loader
    import cfgld_pkg::*;
#(
    parameter int         CLK_DIV    = 250,
    parameter int         NUM_REGS   = REG_BYTES,
    parameter logic [6:0] DEV_ADDR   = ROM_DEV_ADDR,
    parameter logic [7:0] FIRST_WORD = 8'h00
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sda_i,
    output logic                        scl_oe,
    output logic                        sda_oe,
    output logic                        wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_idx,
    output logic [7:0]                  wr_data,
    output logic                        done,
    output logic                        err
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic       tick, eng_idle, rsp_valid, cmd_valid;
    bus_cmd_t   cmd;
    bus_rsp_t   rsp;
    seq_state_e st;
    logic [IDX_W-1:0] idx;
    logic       err_q, done_q;
    logic       last_byte;

    cfgld_tick #(.DIV(CLK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    cfgld_bitengine u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd_valid(cmd_valid),
        .cmd      (cmd),
        .idle     (eng_idle),
        .rsp_valid(rsp_valid),
        .rsp      (rsp),
        .sda_i    (sda_i),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    assign last_byte = (idx == LAST_IDX);
    assign cmd_valid = (st != SQ_DONE) && eng_idle && !rsp_valid;
    assign done      = done_q;
    assign err       = err_q;

    always_comb begin
        cmd = '0;
        case (st)
            SQ_START_W, SQ_START_R: cmd.op = OP_START;
            SQ_DEV_W: begin cmd.op = OP_WRITE; cmd.data = dev_byte(DEV_ADDR, 1'b0); end
            SQ_WORD:  begin cmd.op = OP_WRITE; cmd.data = FIRST_WORD; end
            SQ_DEV_R: begin cmd.op = OP_WRITE; cmd.data = dev_byte(DEV_ADDR, 1'b1); end
            SQ_MARK:  begin cmd.op = OP_READ;  cmd.nack_if_skip = 1'b1; end
            SQ_DATA:  begin cmd.op = OP_READ;  cmd.nack_last = last_byte; end
            SQ_STOP:  cmd.op = OP_STOP;
            default:  cmd.op = OP_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_START_W;
            idx     <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (rsp_valid) begin
                case (st)
                    SQ_START_W: st <= SQ_DEV_W;
                    SQ_START_R: st <= SQ_DEV_R;
                    SQ_DEV_W, SQ_WORD, SQ_DEV_R: begin
                        if (!rsp.peer_ack) begin
                            err_q <= 1'b1;
                            st    <= SQ_STOP;
                        end else if (st == SQ_DEV_W) begin
                            st <= SQ_WORD;
                        end else if (st == SQ_WORD) begin
                            st <= SQ_START_R;
                        end else begin
                            st <= SQ_MARK;
                        end
                    end
                    SQ_MARK: begin
                        idx <= '0;
                        st  <= (rsp.data == SKIP_MARK) ? SQ_STOP : SQ_DATA;
                    end
                    SQ_DATA: begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= rsp.data;
                        if (last_byte) st <= SQ_STOP;
                        else           idx <= idx + 1'b1;
                    end
                    SQ_STOP: begin
                        st     <= SQ_DONE;
                        done_q <= 1'b1;
                    end
                    default: st <= SQ_DONE;
                endcase
            end
        end
    end

    assert_no_write_after_fault_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !err_q);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    assert_released_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!scl_oe && !sda_oe));

    assert_write_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    assert_no_write_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        $past(done_q) |-> !wr_en);

endmodule

// File: tb/sim_cfg_eeprom_loader.sv
`timescale 1ns/1ps
module sim_cfg_eeprom_loader;

    localparam int  DIV   = 4;
    localparam int  NREG  = 20;
    localparam time PER   = 4 * DIV * 8;
    localparam int  LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = !clk;

    logic       scl_oe, sda_oe, wr_en, done, err;
    logic [4:0] wr_idx;
    logic [7:0] wr_data;
    logic       slv_low = 1'b0;

    wire scl_ln = !scl_oe;
    wire sda_ln = !(sda_oe || slv_low);

    cfg_eeprom_loader #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .err(err)
    );

    int n_chk = 0, n_bad = 0, n_wr = 0;
    bit finished = 1'b0;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [7:0] mem [0:31];
    int         nak_sel = 0;              // 1 dev-write, 2 word, 3 dev-read
    logic [7:0] addr_log [0:3];
    int         n_addr, n_mack, n_start, n_stop, bad_per;
    logic       mack_log [0:31];
    int         sph = 0, sbc = 0, snrx = 0;
    logic [7:0] ssh, stx, sptr;
    logic       s_ack, s_go_tx, s_mack, pscl = 1'b1, psda = 1'b1;
    time        tlast = 0;

    always @(scl_ln, sda_ln, rst) begin
        if (rst) begin
            sph = 0; sbc = 0; slv_low = 1'b0;
        end else if (scl_ln !== pscl) begin
            if (scl_ln) begin
                if (sph == 1 && sbc < 8) begin
                    ssh = {ssh[6:0], sda_ln}; sbc++;
                end else if (sph == 2) begin
                    if (sbc >= 2 && ($time - tlast) != PER) bad_per++;
                    if (sbc == 9) begin
                        s_mack = sda_ln;
                        if (n_mack < 32) mack_log[n_mack] = sda_ln;
                        n_mack++;
                    end
                end
                tlast = $time;
            end else begin
                if (sph == 1) begin
                    if (sbc == 8) begin
                        if (n_addr < 4) addr_log[n_addr] = ssh;
                        n_addr++;
                        s_go_tx = 1'b0;
                        if (snrx == 0) begin
                            if (ssh == 8'hA0) s_ack = (nak_sel != 1);
                            else if (ssh == 8'hA1) begin s_ack = (nak_sel != 3); s_go_tx = 1'b1; end
                            else s_ack = 1'b0;
                        end else begin
                            sptr = ssh; s_ack = (nak_sel != 2);
                        end
                        snrx++;
                        slv_low = s_ack; sbc = 9;
                    end else if (sbc == 9) begin
                        slv_low = 1'b0; sbc = 0;
                        if (!s_ack) sph = 0;
                        else if (s_go_tx) begin
                            sph = 2; stx = mem[sptr[4:0]];
                            slv_low = !stx[7]; sbc = 1;
                        end
                    end
                end else if (sph == 2) begin
                    if (sbc < 8) begin
                        slv_low = !stx[7-sbc]; sbc++;
                    end else if (sbc == 8) begin
                        slv_low = 1'b0; sbc = 9;
                    end else if (!s_mack) begin
                        sptr++; stx = mem[sptr[4:0]];
                        slv_low = !stx[7]; sbc = 1;
                    end else begin
                        sph = 0;
                    end
                end
            end
        end else if (sda_ln !== psda && scl_ln) begin
            if (!sda_ln) begin n_start++; sph = 1; sbc = 0; snrx = 0; end
            else begin n_stop++; sph = 0; end
        end
        pscl = scl_ln;
        psda = sda_ln;
    end

    // ---------------- scoreboard ----------------
    logic [12:0] exp_q [$];

    always @(negedge clk) begin
        if (!rst && wr_en) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                chk_eq("R4 unexpected write", 1, 0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                chk_eq("R4 lane index", int'(wr_idx), int'(e[12:8]));
                chk_eq("R4 lane data", int'(wr_data), int'(e[7:0]));
            end
        end
    end

    task automatic setup(input logic [7:0] mark, input int seed, input int nak);
        mem[0] = mark;
        for (int i = 1; i < 32; i++) mem[i] = 8'(i * 29 + seed);
        nak_sel = nak;
        exp_q.delete();
        if (mark != 8'hFF && nak == 0)
            for (int i = 0; i < NREG; i++) exp_q.push_back({5'(i), mem[i+1]});
        n_addr = 0; n_mack = 0; n_start = 0; n_stop = 0; bad_per = 0; n_wr = 0;
    endtask

    task automatic pulse_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done && k < LIMIT) begin @(negedge clk); k++; end
        chk_eq({req, " done reached"}, int'(done), 1);
    endtask

    initial begin
        // reset state (R7)
        setup(8'h5A, 3, 0);
        repeat (4) @(negedge clk);
        chk_eq("R7 done in reset", int'(done), 0);
        chk_eq("R7 err in reset", int'(err), 0);
        chk_eq("R7 wr_en in reset", int'(wr_en), 0);
        chk_eq("R7 lines released in reset", int'(scl_oe || sda_oe), 0);
        rst = 1'b0;

        // normal load
        wait_done("R4");
        chk_eq("R1 first byte A0", int'(addr_log[0]), 8'hA0);
        chk_eq("R1 word address", int'(addr_log[1]), 8'h00);
        chk_eq("R1 read byte A1", int'(addr_log[2]), 8'hA1);
        chk_eq("R2 start count", n_start, 2);
        chk_eq("R2 scl period violations", bad_per, 0);
        chk_eq("R4 write count", n_wr, NREG);
        chk_eq("R4 queue drained", exp_q.size(), 0);
        chk_eq("R4 err clear", int'(err), 0);
        chk_eq("R5 read bytes acked slots", n_mack, NREG + 1);
        for (int i = 0; i < NREG; i++) chk_eq("R5 master ack", int'(mack_log[i]), 0);
        chk_eq("R5 final no-ack", int'(mack_log[NREG]), 1);
        chk_eq("R7 stop before done", n_stop, 1);
        repeat (60) @(negedge clk);
        chk_eq("R7 done held", int'(done), 1);
        chk_eq("R7 bus released", int'(scl_oe || sda_oe), 0);

        // blank marker
        setup(8'hFF, 11, 0);
        pulse_reset();
        wait_done("R3");
        chk_eq("R3 no writes", n_wr, 0);
        chk_eq("R3 err clear", int'(err), 0);
        chk_eq("R3 marker not acked", int'(mack_log[0]), 1);
        chk_eq("R3 one read slot", n_mack, 1);
        chk_eq("R3 stop issued", n_stop, 1);

        // missing acknowledge in each address position
        for (int p = 1; p <= 3; p++) begin
            setup(8'h00, p, p);
            pulse_reset();
            wait_done("R6");
            chk_eq("R6 err set", int'(err), 1);
            chk_eq("R6 no writes", n_wr, 0);
            chk_eq("R6 stop issued", n_stop, 1);
        end

        // reset in the middle of a load
        setup(8'h12, 57, 0);
        pulse_reset();
        begin
            int k;
            k = 0;
            while (n_wr < 5 && k < LIMIT) begin @(negedge clk); k++; end
        end
        chk_eq("R8 partial writes seen", n_wr, 5);
        setup(8'h12, 57, 0);
        pulse_reset();
        wait_done("R8");
        chk_eq("R8 full write count", n_wr, NREG);
        chk_eq("R8 queue drained", exp_q.size(), 0);
        chk_eq("R8 err clear", int'(err), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule